// File: doc/BRIEF.md
# Regulator Channel Enable Sequencer

This block decides, once per clock, whether a single regulator channel is switched on. Two control sources compete for the channel. A software enable bit can switch the channel directly. When a pin-select bit is also set, an external enable pin steers the channel instead. Pin transitions are not passed straight through. Each rising edge of the pin waits out a programmable startup delay, and each falling edge waits out a programmable shutdown delay, before the channel follows.

The block also checks a device-state input. The channel is allowed on only in the standby and active states. A forced-off input from the fault monitor switches the channel off and keeps it off until software re-arms the channel. The single output, `reg_on`, is registered and goes to the regulator's soft-start logic.

The enable pin is asynchronous, so it is synchronised before any edge is seen. Delay codes count in steps of a parameterised number of clock ticks.

Top module: `reg_en_ctrl`

## Requirements
- R1: While `sw_en` is 0, `reg_on` is 0 one clock later, whatever the values of `pin_sel` and `en_pin`.
- R2: With `sw_en`=1 and `pin_sel`=0 (and no other gating), `reg_on` is 1 one clock later, and toggling `en_pin` has no effect on it.
- R3: With `sw_en`=1 and `pin_sel`=1, the channel follows the settled pin level: settled low gives off, settled high gives on.
- R4: In pin mode, a rising `en_pin` drives `reg_on` high exactly 4 + `rise_code`×`TICKS_PER_STEP` clocks after the pin change, and not one clock earlier. The 4 clocks are two synchroniser stages, one delay stage and the output register.
- R5: In pin mode, a falling `en_pin` drives `reg_on` low exactly 4 + `fall_code`×`TICKS_PER_STEP` clocks after the pin change, and not one clock earlier.
- R6: A change of `sw_en` reaches `reg_on` one clock later with no startup or shutdown delay. This holds even when entering pin mode with the pin already high.
- R7: `dev_state` is encoded as 0 = off, 1 = standby, 2 = active and 3 = recovering. Only 1 and 2 allow `reg_on`=1. Any other value gives `reg_on`=0 one clock later.
- R8: A delay code of 0 adds no delay, so a pin edge reaches `reg_on` in exactly 4 clocks.
- R9: If the pin returns to its settled level before a pending delay expires, the transition is cancelled. The count restarts from zero on the next edge.
- R10: `force_off`=1 gives `reg_on`=0 one clock later. The channel then stays off until `sw_en` is seen at 0 and set again.
- R11: `reg_on` is 0 during reset, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_en | input | 1 | Software enable bit |
| pin_sel | input | 1 | Selects the enable pin as control source when `sw_en` is 1 |
| en_pin | input | 1 | Asynchronous external enable pin |
| rise_code | input | CODE_W | Startup delay code, in steps |
| fall_code | input | CODE_W | Shutdown delay code, in steps |
| dev_state | input | 2 | Device state (0 off, 1 standby, 2 active, 3 recovering) |
| force_off | input | 1 | Fault-monitor forced-off request |
| reg_on | output | 1 | Regulator channel on |

## Verification
The assertions check the gating rules on every cycle:
- a cleared enable bit, a disallowed device state, a forced-off request and a held fault latch each force the output off on the next clock;
- register-only mode forces it on;
- the delay counter stays in range and never advances while the pin agrees with its settled level.

Only the bench scenarios can show the exact edge-to-output latency for non-zero and zero codes. They also show cancellation of a pending edge and the re-arm sequence after a fault.

// File: rtl/reg_en_pkg.sv
// Shared definitions for the regulator enable sequencer.
// Assumes a 2-bit device-state code supplied by the power-state machine.
package reg_en_pkg;

    typedef enum logic [1:0] {
        DEV_OFF     = 2'd0,
        DEV_STANDBY = 2'd1,
        DEV_ACTIVE  = 2'd2,
        DEV_RECOVER = 2'd3
    } dev_state_e;

    // True when the device state permits a channel to be switched on.
    function automatic logic state_allows_on(input logic [1:0] st);
        return (st == DEV_STANDBY) || (st == DEV_ACTIVE);
    endfunction

endpackage

// File: rtl/reg_en_pin_sync.sv
// Synchroniser chain for the asynchronous enable pin.
// Assumes the pin is slow compared with clk; the output lags the pin by STAGES clocks.
module reg_en_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            // Single sampling flop when only one stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= pin_async;
            end
            assign pin_sync = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the pin level through the metastability chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
            assign pin_sync = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/reg_en_edge_delay.sv
// Edge delay tracker for the synchronised enable pin.
// Holds a settled pin level that follows the synchronised level only after
// the rise or fall delay (code * TICKS clocks) has expired.
// A return of the pin before expiry cancels the pending transition.
// Outside pin mode the settled level tracks the pin with no delay.
module reg_en_edge_delay #(
    parameter int CODE_W = 4,
    parameter int TICKS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_mode,
    input  logic              pin_lvl,
    input  logic [CODE_W-1:0] rise_code,
    input  logic [CODE_W-1:0] fall_code,
    output logic              pin_eff
);

    localparam int MAX_CNT = ((1 << CODE_W) - 1) * TICKS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1) + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  target;
    logic [CODE_W-1:0] sel_code;
    logic              pin_eff_q;
    logic              mismatch;

    assign mismatch = (pin_lvl != pin_eff_q);

    // Pick the delay for the direction of the pending edge, scaled to clocks.
    always_comb begin
        sel_code = pin_lvl ? rise_code : fall_code;
        target   = CNT_W'(32'(sel_code) * TICKS);
    end

    // Count while the pin disagrees with its settled level; commit on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_eff_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!pin_mode || !mismatch) begin
            pin_eff_q <= pin_lvl;
            cnt_q     <= '0;
        end else if (cnt_q >= target) begin
            pin_eff_q <= pin_lvl;
            cnt_q     <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign pin_eff = pin_eff_q;

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_CNT));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && !mismatch) |=> (cnt_q == '0) && $stable(pin_eff_q));

    // R5
    no_early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && mismatch && (cnt_q < target)) |=> $stable(pin_eff_q));

endmodule

// File: rtl/reg_en_arbiter.sv
// Source selection, state gating and fault latch for one regulator channel.
// Assumes pin_eff is already synchronised and delay-filtered.
// The output is registered, so every gating change lands one clock later.
module reg_en_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_en,
    input  logic       pin_sel,
    input  logic       pin_eff,
    input  logic [1:0] dev_state,
    input  logic       force_off,
    output logic       pin_mode,
    output logic       reg_on
);
    import reg_en_pkg::*;

    logic fault_q;
    logic reg_on_q;
    logic request;
    logic on_next;

    assign pin_mode = sw_en & pin_sel;

    // Combine control source, device state and fault gating.
    always_comb begin
        request = sw_en & (pin_sel ? pin_eff : 1'b1);
        on_next = request & state_allows_on(dev_state) & ~force_off & ~fault_q;
    end

    // Latch a forced-off request until software clears the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_q <= 1'b0;
        else if (force_off) fault_q <= 1'b1;
        else if (!sw_en)    fault_q <= 1'b0;
    end

    // Register the channel-on decision.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_on_q <= 1'b0;
        else        reg_on_q <= on_next;
    end

    assign reg_on = reg_on_q;

    // R1
    sw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> !reg_on_q);

    // R2
    direct_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !pin_sel && state_allows_on(dev_state) && !force_off && !fault_q)
        |=> reg_on_q);

    // R3
    pin_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && !pin_eff) |=> !reg_on_q);

    // R7
    state_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_allows_on(dev_state) |=> !reg_on_q);

    // R10
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!reg_on_q && fault_q));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && sw_en) |=> !reg_on_q);

endmodule

// File: rtl/reg_en_ctrl.sv
// Top level of the regulator channel enable sequencer.
// Chains the pin synchroniser, the edge delay tracker and the arbiter.
// Pin edge to output latency is SYNC_STAGES + 2 + code * TICKS_PER_STEP clocks.
module reg_en_ctrl #(
    parameter int CODE_W         = 4,
    parameter int TICKS_PER_STEP = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic              pin_sel,
    input  logic              en_pin,
    input  logic [CODE_W-1:0] rise_code,
    input  logic [CODE_W-1:0] fall_code,
    input  logic [1:0]        dev_state,
    input  logic              force_off,
    output logic              reg_on
);

    logic pin_s;
    logic pin_eff;
    logic pin_mode;

    reg_en_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (en_pin),
        .pin_sync  (pin_s)
    );

    reg_en_edge_delay #(.CODE_W(CODE_W), .TICKS(TICKS_PER_STEP)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_mode  (pin_mode),
        .pin_lvl   (pin_s),
        .rise_code (rise_code),
        .fall_code (fall_code),
        .pin_eff   (pin_eff)
    );

    reg_en_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_en     (sw_en),
        .pin_sel   (pin_sel),
        .pin_eff   (pin_eff),
        .dev_state (dev_state),
        .force_off (force_off),
        .pin_mode  (pin_mode),
        .reg_on    (reg_on)
    );

endmodule

// File: tb/tb_reg_en_ctrl.sv
// Scoreboard bench: driver tasks queue expected reg_on values with their cycle;
// a monitor pops and compares them as the clocks pass.
module tb_reg_en_ctrl;
    import reg_en_pkg::*;

    localparam int T   = 8;   // ticks per delay step
    localparam int LAT = 4;   // 2 sync + delay stage + output register

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_en = 1'b0;
    logic       pin_sel = 1'b0;
    logic       en_pin = 1'b0;
    logic       force_off = 1'b0;
    logic [3:0] rise_code = 4'd3;
    logic [3:0] fall_code = 4'd2;
    logic [1:0] dev_state = DEV_ACTIVE;
    logic       reg_on;

    reg_en_ctrl #(.CODE_W(4), .TICKS_PER_STEP(T), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .pin_sel(pin_sel), .en_pin(en_pin),
        .rise_code(rise_code), .fall_code(fall_code), .dev_state(dev_state),
        .force_off(force_off), .reg_on(reg_on)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: reg_on=%0b expected %0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int off, input logic v, input string tag);
        sb_q.push_back('{cyc + off, v, tag});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: count edges, sample a quarter period after each, compare queue head.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.cyc < cyc) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL %s: missed sample, actual n/a expected %0b", e.tag, e.val);
                end else begin
                    check(reg_on, e.val, e.tag);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    // Driver.
    initial begin
        // R11: reset holds the output low even with an enable request.
        sw_en = 1'b1;
        tick(3);
        check(reg_on, 1'b0, "R11 reset");
        rst_n = 1'b1;
        expect_at(1, 1'b1, "R2 register enable on");
        drain();

        // R2: pin toggles are ignored in register mode.
        en_pin = 1'b1;
        expect_at(6, 1'b1, "R2 pin high ignored");
        drain();
        en_pin = 1'b0;
        expect_at(6, 1'b1, "R2 pin low ignored");
        drain();

        // R1: enable bit clear wins over pin control.
        sw_en = 1'b0;
        expect_at(1, 1'b0, "R1 enable cleared");
        drain();
        pin_sel = 1'b1;
        en_pin  = 1'b1;
        expect_at(6, 1'b0, "R1 pin high but enable clear");
        drain();
        en_pin = 1'b0;
        tick(4);

        // R3: entering pin mode with pin low keeps the channel off.
        sw_en = 1'b1;
        expect_at(1, 1'b0, "R3 pin low off");
        expect_at(3, 1'b0, "R3 pin low off");
        drain();

        // R4: rising edge with startup delay.
        en_pin = 1'b1;
        expect_at(LAT - 1 + 3 * T, 1'b0, "R4 before startup expiry");
        expect_at(LAT + 3 * T, 1'b1, "R4 startup expiry");
        drain();

        // R5: falling edge with shutdown delay.
        en_pin = 1'b0;
        expect_at(LAT - 1 + 2 * T, 1'b1, "R5 before shutdown expiry");
        expect_at(LAT + 2 * T, 1'b0, "R5 shutdown expiry");
        drain();

        // R9: rising edge cancelled before expiry.
        en_pin = 1'b1;
        tick(10);
        en_pin = 1'b0;
        expect_at(30, 1'b0, "R9 cancelled startup");
        drain();
        // R9: a fresh edge counts the full delay again.
        en_pin = 1'b1;
        expect_at(LAT - 1 + 3 * T, 1'b0, "R9 restart before expiry");
        expect_at(LAT + 3 * T, 1'b1, "R9 restart full delay");
        drain();
        // R9: falling edge cancelled before expiry.
        en_pin = 1'b0;
        tick(8);
        en_pin = 1'b1;
        expect_at(25, 1'b1, "R9 cancelled shutdown");
        drain();

        // R8: zero codes give only the pipeline latency.
        fall_code = 4'd0;
        en_pin = 1'b0;
        expect_at(LAT - 1, 1'b1, "R8 zero shutdown early");
        expect_at(LAT, 1'b0, "R8 zero shutdown");
        drain();
        rise_code = 4'd0;
        en_pin = 1'b1;
        expect_at(LAT - 1, 1'b0, "R8 zero startup early");
        expect_at(LAT, 1'b1, "R8 zero startup");
        drain();
        rise_code = 4'd3;
        fall_code = 4'd2;
        tick(2);

        // R6: software bit acts with no delay, even in pin mode.
        sw_en = 1'b0;
        expect_at(1, 1'b0, "R6 software off no delay");
        drain();
        sw_en = 1'b1;
        expect_at(1, 1'b1, "R6 software on no delay");
        drain();

        // R7: device-state gating.
        dev_state = DEV_OFF;
        expect_at(1, 1'b0, "R7 off state");
        drain();
        dev_state = DEV_STANDBY;
        expect_at(1, 1'b1, "R7 standby state");
        drain();
        dev_state = DEV_RECOVER;
        expect_at(1, 1'b0, "R7 recover state");
        drain();
        dev_state = DEV_ACTIVE;
        expect_at(1, 1'b1, "R7 active state");
        drain();

        // R10: forced off, latched until re-enable.
        force_off = 1'b1;
        expect_at(1, 1'b0, "R10 forced off");
        expect_at(6, 1'b0, "R10 held off");
        tick(1);
        force_off = 1'b0;
        drain();
        sw_en = 1'b0;
        tick(2);
        sw_en = 1'b1;
        expect_at(1, 1'b1, "R10 re-enabled");
        drain();

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule